// File: doc/BRIEF.md
# Eight-Channel Overcurrent Protection Controller

This block holds the digital control and protection logic for an eight-channel high-side load switch. Each channel has an active-high command. Its registered gate-enable output follows that command while the common enable/clear input is high, the die is not in thermal shutdown, and the channel has not tripped. Analog current sensing lies outside the block. The block receives it as one comparator flag per channel.

Each channel has its own trip latch and its own blanking counter. The counter restarts every time the gate turns on. While it runs, the overcurrent flag is ignored, so inrush or crossover current cannot trip the channel. A trip turns off only that channel and holds it off until the latch is cleared. Three things clear the latches: enable/clear low, thermal shutdown, or reset.

A hysteresis comparator reads the digitised die temperature. When it enters shutdown it turns off every output and clears every latch. A common active-low fault output reports any tripped channel or a thermal shutdown.

Top module: `ocp_ctrl8`

## Requirements
- R1: `gate[i]` is 1 in the cycle after an edge where `cmd[i]`=1, `en_clr`=1, thermal shutdown is inactive and channel i is not tripped. It is 0 in the cycle after an edge where any of these does not hold.
- R2: With `en_clr`=0 (its safe default level), all gates are 0 after the next edge and all trip latches are clear after that edge.
- R3: A trip on one channel turns off and latches only that channel. The other channels keep following their commands.
- R4: `oc_flag[i]` has no effect until channel i's gate has been on for `BLANK_CYC` consecutive edges. The count restarts each time the gate turns on. With the flag held high from turn-on, the gate stays 1 for `BLANK_CYC`+1 cycles.
- R5: A tripped channel stays off, whatever `cmd[i]` does, until the latch is cleared by `en_clr`=0, thermal shutdown or `rst`.
- R6: Thermal shutdown enters at the edge after `die_temp` > `T_HI` (unsigned degrees C, default 165). It leaves at the edge after `die_temp` <= `T_LO` (default 150). Between the two thresholds it keeps its state.
- R7: While thermal shutdown is active, all gates are 0 and all trip latches are cleared. The gates drop one cycle after shutdown enters and return one cycle after it leaves.
- R8: `fault_n` is 0 in the cycle after any latch is set or shutdown is active, and 1 otherwise.
- R9: While `rst`=1, all gates are 0 after each edge, `fault_n` is 1, and latches and thermal state are cleared, whatever `en_clr` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| en_clr | input | 1 | Common enable; low forces outputs off and clears trips |
| cmd | input | N | Per-channel on command, active high |
| oc_flag | input | N | Per-channel overcurrent comparator flag |
| die_temp | input | TW | Die temperature, unsigned whole degrees C |
| gate | output | N | Registered per-channel gate enable |
| fault_n | output | 1 | Registered common fault, active low |

## Verification
The assertions assume the inputs are synchronous and settle before each clock edge. They also assume `die_temp` is a plain unsigned code. Nothing else constrains the inputs: any command, flag or enable pattern is legal. The bench changes inputs just after the rising edge and holds them for whole cycles. It drives temperatures exactly at, and one degree beyond, each threshold. It raises overcurrent flags only in the cycles where the blanking and trip timing is under test.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic {TS_NORMAL = 1'b0, TS_SHUTDOWN = 1'b1} therm_state_e;
endpackage

// File: rtl/ocp_thermal.sv
module ocp_thermal #(
  parameter int TW   = 8,
  parameter int T_HI = 165,
  parameter int T_LO = 150
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] die_temp,
  output logic          shutdown
);
  import ocp_pkg::*;
  localparam logic [TW-1:0] HI_C = TW'(T_HI);
  localparam logic [TW-1:0] LO_C = TW'(T_LO);

  therm_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      TS_NORMAL:   if (die_temp > HI_C)  state_d = TS_SHUTDOWN;
      TS_SHUTDOWN: if (die_temp <= LO_C) state_d = TS_NORMAL;
      default:     state_d = TS_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= TS_NORMAL;
    else     state_q <= state_d;
  end

  assign shutdown = (state_q == TS_SHUTDOWN);
endmodule

// File: rtl/ocp_channel.sv
module ocp_channel #(
  parameter int BLANK_CYC = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd,
  input  logic oc_flag,
  input  logic allow,
  input  logic clr,
  output logic gate,
  output logic tripped
);
  localparam int CW = (BLANK_CYC < 1) ? 1 : $clog2(BLANK_CYC + 1);
  localparam logic [CW-1:0] BL_C = CW'(BLANK_CYC);

  logic [CW-1:0] cnt_q;
  logic          gate_q, trip_q;
  logic          blank_over, trip_now, drive;

  assign blank_over = (cnt_q == BL_C);
  assign trip_now   = gate_q & blank_over & oc_flag;
  assign drive      = cmd & allow & ~trip_q & ~trip_now;

  always_ff @(posedge clk) begin
    if (rst)          gate_q <= 1'b0;
    else              gate_q <= drive;
  end

  always_ff @(posedge clk) begin
    if (rst || !gate_q)   cnt_q <= '0;
    else if (!blank_over) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)    trip_q <= 1'b0;
    else if (trip_now) trip_q <= 1'b1;
  end

  assign gate    = gate_q;
  assign tripped = trip_q;
endmodule

// File: rtl/ocp_fault.sv
module ocp_fault #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] tripped,
  input  logic         shutdown,
  output logic         fault_n
);
  logic fault_n_q;
  always_ff @(posedge clk) begin
    if (rst) fault_n_q <= 1'b1;
    else     fault_n_q <= ~((|tripped) | shutdown);
  end
  assign fault_n = fault_n_q;
endmodule

// File: rtl/ocp_ctrl8.sv
module ocp_ctrl8 #(
  parameter int N         = 8,
  parameter int BLANK_CYC = 50,
  parameter int TW        = 8,
  parameter int T_HI      = 165,
  parameter int T_LO      = 150
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_clr,
  input  logic [N-1:0]  cmd,
  input  logic [N-1:0]  oc_flag,
  input  logic [TW-1:0] die_temp,
  output logic [N-1:0]  gate,
  output logic          fault_n
);
  logic         tsd_q;
  logic [N-1:0] latch_q;
  logic         allow, clr;

  ocp_thermal #(.TW(TW), .T_HI(T_HI), .T_LO(T_LO)) u_therm (
    .clk(clk), .rst(rst), .die_temp(die_temp), .shutdown(tsd_q)
  );

  assign allow = en_clr & ~tsd_q;
  assign clr   = ~en_clr | tsd_q;

  for (genvar i = 0; i < N; i++) begin : g_ch
    ocp_channel #(.BLANK_CYC(BLANK_CYC)) u_ch (
      .clk(clk), .rst(rst), .cmd(cmd[i]), .oc_flag(oc_flag[i]),
      .allow(allow), .clr(clr), .gate(gate[i]), .tripped(latch_q[i])
    );
  end

  ocp_fault #(.N(N)) u_fault (
    .clk(clk), .rst(rst), .tripped(latch_q), .shutdown(tsd_q), .fault_n(fault_n)
  );
endmodule

// File: rtl/ocp_ctrl8_chk.sv
module ocp_ctrl8_chk #(
  parameter int N    = 8,
  parameter int TW   = 8,
  parameter int T_HI = 165,
  parameter int T_LO = 150
) (
  input logic          clk,
  input logic          rst,
  input logic          en_clr,
  input logic [N-1:0]  cmd,
  input logic [TW-1:0] die_temp,
  input logic [N-1:0]  gate,
  input logic          fault_n,
  input logic [N-1:0]  latch,
  input logic          tsd
);
  localparam logic [TW-1:0] HI_C = TW'(T_HI);
  localparam logic [TW-1:0] LO_C = TW'(T_LO);

  a_r1_gate_needs_cmd: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((gate & ~$past(cmd)) == '0));
  a_r2_enable_low_off: assert property (@(posedge clk) disable iff (rst)
    !en_clr |=> (gate == '0 && latch == '0));
  a_r5_latch_holds_off: assert property (@(posedge clk) disable iff (rst)
    (|latch) |=> ((gate & $past(latch)) == '0));
  a_r6_enter_above_hi: assert property (@(posedge clk) disable iff (rst)
    $rose(tsd) |-> ($past(die_temp) > HI_C));
  a_r6_leave_at_lo: assert property (@(posedge clk) disable iff (rst)
    $fell(tsd) |-> ($past(die_temp) <= LO_C));
  a_r7_shutdown_off: assert property (@(posedge clk) disable iff (rst)
    tsd |=> (gate == '0 && latch == '0));
  a_r8_fault_active: assert property (@(posedge clk) disable iff (rst)
    ((|latch) || tsd) |=> !fault_n);
  a_r9_reset_state: assert property (@(posedge clk)
    rst |=> (gate == '0 && fault_n && latch == '0 && !tsd));
endmodule

bind ocp_ctrl8 ocp_ctrl8_chk #(.N(N), .TW(TW), .T_HI(T_HI), .T_LO(T_LO)) u_chk (
  .clk(clk), .rst(rst), .en_clr(en_clr), .cmd(cmd), .die_temp(die_temp),
  .gate(gate), .fault_n(fault_n), .latch(latch_q), .tsd(tsd_q)
);

// File: tb/test_ocp_ctrl8.sv
module test_ocp_ctrl8;
  localparam int BL = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en_clr = 1'b1;
  logic [7:0] cmd = 8'hFF;
  logic [7:0] oc_flag = 8'hFF;
  logic [7:0] die_temp = 8'd25;
  logic [7:0] gate;
  logic       fault_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] g;
    logic       f;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  ocp_ctrl8 #(.N(8), .BLANK_CYC(BL), .TW(8), .T_HI(165), .T_LO(150)) i_ocp_ctrl8 (
    .clk(clk), .rst(rst), .en_clr(en_clr), .cmd(cmd), .oc_flag(oc_flag),
    .die_temp(die_temp), .gate(gate), .fault_n(fault_n)
  );

  // Driver: advance one edge, then push what the outputs must show after it.
  task automatic step(input logic [7:0] g, input logic f, input string tag);
    @(posedge clk);
    #1;
    sb.push_back('{g: g, f: f, tag: tag});
  endtask

  // Monitor: compare away from the active edge.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (gate !== e.g || fault_n !== e.f) begin
        failures++;
        $display("FAIL %s gate=%h fault_n=%b expected gate=%h fault_n=%b",
                 e.tag, gate, fault_n, e.g, e.f);
      end
    end
  end

  initial begin
    // R9: reset with enable high and flags set
    step(8'h00, 1'b1, "R9 reset");
    step(8'h00, 1'b1, "R9 reset");
    rst = 1'b0; oc_flag = 8'h00; en_clr = 1'b0;
    step(8'h00, 1'b1, "R2 enable low");
    en_clr = 1'b1; cmd = 8'hA5;
    step(8'hA5, 1'b1, "R1 pattern A5");
    cmd = 8'h3C;
    step(8'h3C, 1'b1, "R1 pattern 3C");
    cmd = 8'hFF;
    for (int k = 0; k < BL + 2; k++) step(8'hFF, 1'b1, "R1 all on");

    // R4 and R3: restart ch0 with its flag high from turn-on
    cmd = 8'hFE;
    step(8'hFE, 1'b1, "R1 ch0 off");
    cmd = 8'hFF; oc_flag = 8'h01;
    step(8'hFF, 1'b1, "R4 ch0 on");
    for (int k = 0; k < BL; k++) step(8'hFF, 1'b1, "R4 blanking");
    step(8'hFE, 1'b1, "R3 ch0 trips alone");
    step(8'hFE, 1'b0, "R8 fault after trip");
    oc_flag = 8'h00;

    // R5: command toggles do not revive a tripped channel
    cmd = 8'hFE;
    step(8'hFE, 1'b0, "R5 cmd low");
    cmd = 8'hFF;
    step(8'hFE, 1'b0, "R5 cmd high");
    step(8'hFE, 1'b0, "R5 hold");

    // R2: enable low clears the trip
    en_clr = 1'b0;
    step(8'h00, 1'b0, "R2 outputs off");
    step(8'h00, 1'b1, "R2 latch cleared");
    en_clr = 1'b1;
    step(8'hFF, 1'b1, "R2 channel recovers");
    for (int k = 0; k < BL + 1; k++) step(8'hFF, 1'b1, "R1 settle");

    // R3: trip ch3 after blanking has elapsed
    oc_flag = 8'h08;
    step(8'hF7, 1'b1, "R3 ch3 trips alone");
    oc_flag = 8'h00;
    step(8'hF7, 1'b0, "R8 fault ch3");

    // R6, R7: thermal thresholds
    die_temp = 8'd165;
    step(8'hF7, 1'b0, "R6 at 165 no shutdown");
    die_temp = 8'd166;
    step(8'hF7, 1'b0, "R6 shutdown enters");
    step(8'h00, 1'b0, "R7 all off");
    die_temp = 8'd151;
    step(8'h00, 1'b0, "R6 hold at 151");
    die_temp = 8'd150;
    step(8'h00, 1'b0, "R6 release at 150");
    step(8'hFF, 1'b1, "R7 latches cleared");
    die_temp = 8'd160;
    step(8'hFF, 1'b1, "R6 no reentry at 160");

    repeat (2) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    for (int k = 0; k < 5000 && !done; k++) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule